// File: doc/BRIEF.md
# Serial Transceiver with Request/Clear-to-Send Handshaking

This block is an asynchronous serial transceiver for 8N1 characters: one start bit at zero, eight data bits sent least significant bit first, one stop bit at one, and a line that idles high. A shared baud generator produces a tick every `DIV` clocks, and both directions run at sixteen ticks per bit. The transmit side accepts a byte through a valid/ready pair. The receive side reports each good byte with a one-cycle strobe.

A two-bit mode input selects the line discipline. The value 2 turns on handshaking, and any other value gives plain operation in which the flow-control pins play no part. In handshaking mode the request-to-send output tells the far end whether it may send. The output is high while the receiver is disabled, and also while a receive-buffer allowance has run out. That allowance is a small down-counter that stands in for a receive buffer channel. It is loaded with a character count, counts down once per received character, and raises a buffer-full flag when it reaches zero. The clear-to-send input is synchronised and looked at only when the transmitter is about to begin a character. A character already on the wire is therefore never cut short.

Top module: `uart_hs`

## Requirements
- R1: Every transmitted character is framed as start 0, eight data bits LSB first, and stop 1, with each bit lasting 16*DIV clocks. The TXD line idles at 1.
- R2: `tx_ready_o` is high only while the transmitter is idle and `tx_en_i` is 1, and, in handshaking mode, while the synchronised CTS is low. Accepted bytes leave in the order they were accepted.
- R3: The receiver samples each bit at its middle. It pulses `rx_valid_o` for exactly one cycle with the byte, but only if the stop bit reads 1. Bytes are delivered in arrival order.
- R4: A falling edge on RXD whose level is back at 1 by the middle of the start bit (8 ticks later) is dropped, and no byte results.
- R5: Mode value 2 selects handshaking. With any other mode value, `rts_o` is 0 and CTS has no effect on transmission.
- R6: In handshaking mode, `rts_o` is 1 whenever `rx_en_i` is 0.
- R7: The buffer-full flag is 1 after reset. A load with a count N greater than 0 clears it on the next cycle. In handshaking mode each received byte decrements the count, and the flag sets once N bytes have arrived. In handshaking mode `rts_o` = NOT `rx_en_i` OR full.
- R8: In handshaking mode, while the buffer-full flag is set, a frame arriving on RXD is discarded.
- R9: When CTS rises while a character is being shifted out, that character completes including its stop bit. No new character starts while CTS stays high.
- R10: When CTS returns low with a byte pending, its start bit appears on TXD within 4 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Line discipline; 2 = handshaking |
| rx_en_i | input | 1 | Receiver enable |
| tx_en_i | input | 1 | Transmitter enable |
| buf_load_i | input | 1 | One-cycle pulse loading a new receive allowance |
| buf_count_i | input | CW | Character count for the allowance |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Byte offered |
| tx_ready_o | output | 1 | Byte accepted when high together with valid |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| rx_full_o | output | 1 | Receive allowance exhausted |
| txd_o | output | 1 | Serial output |
| rxd_i | input | 1 | Serial input |
| rts_o | output | 1 | Request to send, high means hold off |
| cts_i | input | 1 | Clear to send, high means pause |

## Verification
The hardest state to reach is CTS rising in the middle of a character while a second byte is already waiting at the transmitter's input. To get there, the bench starts one byte and raises CTS about a third of the way into its frame. It then offers the next byte from a background task. The bench checks that the first frame is decoded whole with its stop bit, that the line and ready stay idle for a long window, and that the waiting byte starts within a few clocks of CTS falling. The buffer exhaustion path is driven by a remote model that obeys RTS, and also by one frame that deliberately ignores it.

// File: rtl/uart_hs_pkg.sv
package uart_hs_pkg;

    localparam int OSR      = 16;
    localparam int HALF_OSR = OSR / 2;
    localparam logic [1:0] MODE_HS = 2'd2;

    typedef enum logic [1:0] {
        LN_IDLE,
        LN_START,
        LN_DATA,
        LN_STOP
    } line_st_e;

    typedef struct packed {
        line_st_e    st;
        logic [3:0]  ph;
        logic [2:0]  idx;
        logic [7:0]  sh;
    } line_ctx_t;

    function automatic logic is_hs(input logic [1:0] mode);
        return mode == MODE_HS;
    endfunction

endpackage

// File: rtl/uart_hs_baud.sv
module uart_hs_baud #(
    parameter int DIV = 27
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick_o = (cnt == LAST);
endmodule

// File: rtl/uart_hs_tx.sv
module uart_hs_tx
    import uart_hs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       en_i,
    input  logic       hs_i,
    input  logic       cts_i,
    input  logic [7:0] data_i,
    input  logic       valid_i,
    output logic       ready_o,
    output logic       txd_o
);
    logic [1:0] cts_q;
    line_ctx_t  ctx;
    logic       last_ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            cts_q <= 2'b00;
        end else begin
            cts_q <= {cts_q[0], cts_i};
        end
    end

    assign ready_o = (ctx.st == LN_IDLE) && en_i && !(hs_i && cts_q[1]);
    assign last_ph = (ctx.ph == 4'(OSR - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx   <= '{st: LN_IDLE, ph: '0, idx: '0, sh: '0};
            txd_o <= 1'b1;
        end else begin
            case (ctx.st)
                LN_IDLE: begin
                    if (valid_i && ready_o) begin
                        ctx.st <= LN_START;
                        ctx.ph <= '0;
                        ctx.sh <= data_i;
                        txd_o  <= 1'b0;
                    end
                end
                LN_START: begin
                    if (tick_i) begin
                        ctx.ph <= ctx.ph + 1'b1;
                        if (last_ph) begin
                            ctx.st  <= LN_DATA;
                            ctx.idx <= '0;
                            txd_o   <= ctx.sh[0];
                        end
                    end
                end
                LN_DATA: begin
                    if (tick_i) begin
                        ctx.ph <= ctx.ph + 1'b1;
                        if (last_ph) begin
                            if (ctx.idx == 3'd7) begin
                                ctx.st <= LN_STOP;
                                txd_o  <= 1'b1;
                            end else begin
                                ctx.idx <= ctx.idx + 1'b1;
                                ctx.sh  <= {1'b0, ctx.sh[7:1]};
                                txd_o   <= ctx.sh[1];
                            end
                        end
                    end
                end
                default: begin
                    if (tick_i) begin
                        ctx.ph <= ctx.ph + 1'b1;
                        if (last_ph) begin
                            ctx.st <= LN_IDLE;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/uart_hs_rx.sv
module uart_hs_rx
    import uart_hs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       go_i,
    input  logic       rxd_i,
    output logic [7:0] data_o,
    output logic       valid_o
);
    logic [1:0] rxd_q;
    logic       rxd_s;
    line_ctx_t  ctx;

    assign rxd_s = rxd_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            rxd_q <= 2'b11;
        end else begin
            rxd_q <= {rxd_q[0], rxd_i};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx     <= '{st: LN_IDLE, ph: '0, idx: '0, sh: '0};
            data_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            case (ctx.st)
                LN_IDLE: begin
                    if (go_i && !rxd_s) begin
                        ctx.st <= LN_START;
                        ctx.ph <= '0;
                    end
                end
                LN_START: begin
                    if (tick_i) begin
                        ctx.ph <= ctx.ph + 1'b1;
                        if (ctx.ph == 4'(HALF_OSR - 1)) begin
                            ctx.ph <= '0;
                            ctx.idx <= '0;
                            ctx.st <= rxd_s ? LN_IDLE : LN_DATA;
                        end
                    end
                end
                LN_DATA: begin
                    if (tick_i) begin
                        ctx.ph <= ctx.ph + 1'b1;
                        if (ctx.ph == 4'(OSR - 1)) begin
                            ctx.sh  <= {rxd_s, ctx.sh[7:1]};
                            ctx.idx <= ctx.idx + 1'b1;
                            if (ctx.idx == 3'd7) begin
                                ctx.st <= LN_STOP;
                            end
                        end
                    end
                end
                default: begin
                    if (tick_i) begin
                        ctx.ph <= ctx.ph + 1'b1;
                        if (ctx.ph == 4'(OSR - 1)) begin
                            ctx.st <= LN_IDLE;
                            if (rxd_s) begin
                                data_o  <= ctx.sh;
                                valid_o <= 1'b1;
                            end
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/uart_hs_bufchan.sv
module uart_hs_bufchan #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [CW-1:0] count_i,
    input  logic          take_i,
    output logic          full_o
);
    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left   <= '0;
            full_o <= 1'b1;
        end else if (load_i) begin
            left   <= count_i;
            full_o <= (count_i == '0);
        end else if (take_i && !full_o) begin
            left <= left - 1'b1;
            if (left == CW'(1)) begin
                full_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_hs.sv
module uart_hs
    import uart_hs_pkg::*;
#(
    parameter int DIV = 27,
    parameter int CW  = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode_i,
    input  logic          rx_en_i,
    input  logic          tx_en_i,
    input  logic          buf_load_i,
    input  logic [CW-1:0] buf_count_i,
    input  logic [7:0]    tx_data_i,
    input  logic          tx_valid_i,
    output logic          tx_ready_o,
    output logic [7:0]    rx_data_o,
    output logic          rx_valid_o,
    output logic          rx_full_o,
    output logic          txd_o,
    input  logic          rxd_i,
    output logic          rts_o,
    input  logic          cts_i
);
    logic tick;
    logic hs;
    logic rx_go;

    assign hs    = is_hs(mode_i);
    assign rx_go = rx_en_i && !(hs && rx_full_o);
    assign rts_o = hs && (!rx_en_i || rx_full_o);

    uart_hs_baud #(.DIV(DIV)) i_baud (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    uart_hs_tx i_tx (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick),
        .en_i    (tx_en_i),
        .hs_i    (hs),
        .cts_i   (cts_i),
        .data_i  (tx_data_i),
        .valid_i (tx_valid_i),
        .ready_o (tx_ready_o),
        .txd_o   (txd_o)
    );

    uart_hs_rx i_rx (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick),
        .go_i    (rx_go),
        .rxd_i   (rxd_i),
        .data_o  (rx_data_o),
        .valid_o (rx_valid_o)
    );

    uart_hs_bufchan #(.CW(CW)) i_buf (
        .clk     (clk),
        .rst     (rst),
        .load_i  (buf_load_i),
        .count_i (buf_count_i),
        .take_i  (hs && rx_valid_o),
        .full_o  (rx_full_o)
    );
endmodule

// File: rtl/uart_hs_chk.sv
module uart_hs_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    mode_i,
    input logic          buf_load_i,
    input logic [CW-1:0] buf_count_i,
    input logic          tx_ready_o,
    input logic          rx_valid_o,
    input logic          rx_full_o,
    input logic          txd_o,
    input logic          cts_i
);
    logic [1:0] cts_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cts_run <= 2'd0;
        end else if (!cts_i) begin
            cts_run <= 2'd0;
        end else if (cts_run != 2'd3) begin
            cts_run <= cts_run + 2'd1;
        end
    end

    // R3
    rxv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o);

    // R7
    load_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_load_i && buf_count_i != '0) |=> !rx_full_o);

    // R7
    full_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_full_o) |-> ($past(rx_valid_o) || $past(buf_load_i)));

    // R9
    cts_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd2 && cts_run == 2'd3) |-> !tx_ready_o);

    // R2
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        tx_ready_o |-> txd_o);
endmodule

bind uart_hs uart_hs_chk #(.CW(CW)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (mode_i),
    .buf_load_i  (buf_load_i),
    .buf_count_i (buf_count_i),
    .tx_ready_o  (tx_ready_o),
    .rx_valid_o  (rx_valid_o),
    .rx_full_o   (rx_full_o),
    .txd_o       (txd_o),
    .cts_i       (cts_i)
);

// File: tb/test_uart_hs.sv
`timescale 1ns/1ps
module test_uart_hs;
    localparam int DIV = 2;
    localparam int CW  = 8;
    localparam int BIT = 16 * DIV;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode = 2'd2;
    logic          rx_en = 1'b0;
    logic          tx_en = 1'b0;
    logic          buf_load = 1'b0;
    logic [CW-1:0] buf_count = '0;
    logic [7:0]    tx_data = '0;
    logic          tx_valid = 1'b0;
    logic          tx_ready;
    logic [7:0]    rx_data;
    logic          rx_valid;
    logic          rx_full;
    logic          txd;
    logic          rxd = 1'b1;
    logic          rts;
    logic          cts = 1'b0;

    int compared = 0;
    int mismatched = 0;
    int rx_seen = 0;
    int tx_seen = 0;
    bit done = 1'b0;
    logic [7:0] exp_rx[$];
    logic [7:0] exp_tx[$];

    always #5 clk = ~clk;

    uart_hs #(.DIV(DIV), .CW(CW)) i_uart_hs (
        .clk (clk), .rst (rst), .mode_i (mode), .rx_en_i (rx_en),
        .tx_en_i (tx_en), .buf_load_i (buf_load), .buf_count_i (buf_count),
        .tx_data_i (tx_data), .tx_valid_i (tx_valid), .tx_ready_o (tx_ready),
        .rx_data_o (rx_data), .rx_valid_o (rx_valid), .rx_full_o (rx_full),
        .txd_o (txd), .rxd_i (rxd), .rts_o (rts), .cts_i (cts)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_buf(input int n);
        @(negedge clk);
        buf_count = CW'(n);
        buf_load  = 1'b1;
        @(negedge clk);
        buf_load  = 1'b0;
    endtask

    // remote side: drives one frame on RXD, optionally obeying RTS
    task automatic remote_send(input logic [7:0] b, input bit obey, input bit expect_it);
        if (obey) begin
            while (rts) @(negedge clk);
        end
        if (expect_it) exp_rx.push_back(b);
        @(negedge clk);
        rxd = 1'b0;
        wait_clk(BIT);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            wait_clk(BIT);
        end
        rxd = 1'b1;
        wait_clk(BIT + BIT / 2);
    endtask

    task automatic tx_send(input logic [7:0] b);
        @(negedge clk);
        exp_tx.push_back(b);
        tx_data  = b;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    // R3: receive monitor
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            rx_seen++;
            if (exp_rx.size() == 0) begin
                check(1'b0, "R3/R8 unexpected byte", rx_data, 0);
            end else begin
                logic [7:0] e;
                e = exp_rx.pop_front();
                check(rx_data == e, "R3 rx byte order", rx_data, e);
            end
        end
    end

    // R1/R9: line monitor decoding TXD
    initial begin
        logic [7:0] got;
        logic [7:0] e;
        @(negedge clk);
        while (rst) @(negedge clk);
        forever begin
            while (txd) @(negedge clk);
            wait_clk(BIT / 2);
            check(txd == 1'b0, "R1 start bit", txd, 0);
            for (int i = 0; i < 8; i++) begin
                wait_clk(BIT);
                got[i] = txd;
            end
            wait_clk(BIT);
            check(txd == 1'b1, "R9 stop bit present", txd, 1);
            tx_seen++;
            if (exp_tx.size() == 0) begin
                check(1'b0, "R2 unexpected frame", got, 0);
            end else begin
                e = exp_tx.pop_front();
                check(got == e, "R1 tx byte", got, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int n;
        int cycles;
        bit ok;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        // reset state
        check(txd == 1'b1, "R1 idle line", txd, 1);
        check(rts == 1'b1, "R6 rts with rx off", rts, 1);
        check(rx_full == 1'b1, "R7 full after reset", rx_full, 1);
        check(tx_ready == 1'b0, "R2 ready without enable", tx_ready, 0);

        rx_en = 1'b1;
        wait_clk(2);
        check(rts == 1'b1, "R7 rts high before load", rts, 1);
        load_buf(3);
        check(rts == 1'b0 && rx_full == 1'b0, "R7 rts low after load", rts, 0);

        remote_send(8'hA5, 1'b1, 1'b1);
        remote_send(8'h3C, 1'b1, 1'b1);
        check(rts == 1'b0, "R7 rts low with allowance left", rts, 0);
        remote_send(8'h81, 1'b1, 1'b1);
        wait_clk(2);
        check(rts == 1'b1 && rx_full == 1'b1, "R7 rts high after exhaustion", rts, 1);

        n = rx_seen;
        remote_send(8'h55, 1'b0, 1'b0);
        wait_clk(BIT);
        check(rx_seen == n, "R8 frame dropped while full", rx_seen, n);

        load_buf(2);
        check(rts == 1'b0, "R7 rts low after reload", rts, 0);
        remote_send(8'h12, 1'b1, 1'b1);
        remote_send(8'hFE, 1'b1, 1'b1);
        wait_clk(2);
        check(rts == 1'b1, "R7 rts high after second exhaustion", rts, 1);

        load_buf(1);
        n = rx_seen;
        @(negedge clk);
        rxd = 1'b0;
        wait_clk(6);
        rxd = 1'b1;
        wait_clk(12 * BIT);
        check(rx_seen == n, "R4 glitch rejected", rx_seen, n);
        remote_send(8'h77, 1'b1, 1'b1);
        wait_clk(2);
        check(rx_seen == n + 1, "R4 good frame after glitch", rx_seen, n + 1);

        load_buf(5);
        check(rts == 1'b0, "R6 rts low with rx on", rts, 0);
        @(negedge clk);
        rx_en = 1'b0;
        @(negedge clk);
        check(rts == 1'b1, "R6 rts high after rx off", rts, 1);

        // transmit, handshaking mode
        tx_en = 1'b1;
        tx_send(8'h5A);
        tx_send(8'hC3);
        wait_clk(12 * BIT);
        check(tx_seen == 2, "R2 two frames sent in order", tx_seen, 2);

        tx_send(8'h96);
        wait_clk(100);
        cts = 1'b1;
        fork
            tx_send(8'h4B);
        join_none
        wait_clk(400);
        ok = 1'b1;
        for (int i = 0; i < 100; i++) begin
            if (txd !== 1'b1 || tx_ready !== 1'b0) ok = 1'b0;
            @(negedge clk);
        end
        check(ok, "R9 paused while cts high", ok, 1);
        check(tx_seen == 3, "R9 frame in flight completed", tx_seen, 3);
        cts = 1'b0;
        cycles = 0;
        while (txd && cycles < 50) begin
            @(negedge clk);
            cycles++;
        end
        check(cycles <= 4, "R10 resume after cts low", cycles, 4);
        wait_clk(12 * BIT);
        check(tx_seen == 4, "R10 pending frame sent", tx_seen, 4);

        // plain mode
        mode = 2'd0;
        @(negedge clk);
        check(rts == 1'b0, "R5 rts low in plain mode", rts, 0);
        cts = 1'b1;
        wait_clk(4);
        check(tx_ready == 1'b1, "R5 cts ignored in plain mode", tx_ready, 1);
        tx_send(8'hE1);
        wait_clk(12 * BIT);
        check(tx_seen == 5, "R5 plain frame sent", tx_seen, 5);
        cts = 1'b0;
        rx_en = 1'b1;
        remote_send(8'h3D, 1'b0, 1'b1);
        wait_clk(BIT);

        check(exp_rx.size() == 0, "R3 all rx delivered", exp_rx.size(), 0);
        check(exp_tx.size() == 0, "R2 all tx delivered", exp_tx.size(), 0);
        finish_run();
    end
endmodule